// File: doc/BRIEF.md
# Timer Channel Pin Driver

This block owns the output pin and the output buffer enable of every channel in a multi-channel timer engine. Each channel keeps two preset levels: one that the pin takes when a match event arrives, and one it takes when a transition event arrives. A force command sets the pin level at once, without waiting for an event. All of these commands are strobes. A strobe may come in on any clock, and the block keeps it pending until the next microcycle boundary. A microcycle is two system clocks. Levels and buffer enables change only at microcycle boundaries, and they always come straight from flip-flops.

Four engine-wide disable lines can override the channel logic on any pin. Each channel has a small configuration that holds three things: which of the four lines it follows, whether the override is armed, and which level the override drives. While the override is active, the channel's own level keeps updating in the background. The pin returns to that level as soon as the selected line drops. The buffer enable of each channel is written separately through its own control strobe. Configuration and level data arrive on shared buses, and a per-channel write strobe picks the target channel.

Top module: `tpc_pin_ctrl`

## Requirements
- R1: After synchronous reset, every pin and buffer enable is 0, every override is unarmed, and both preset levels of every channel are 0. While this holds, raising disable lines leaves all pins at 0.
- R2: After reset, the microcycle phase starts at 0. Pins and buffer enables change only at the second clock edge after reset and then at every second edge. A strobe seen on the first edge of a microcycle takes effect at the following edge.
- R3: A match strobe makes the channel level equal to its preset match level at the next boundary.
- R4: A transition strobe with no match strobe in the same microcycle makes the channel level equal to its preset transition level.
- R5: When a match strobe and a transition strobe fall in the same microcycle, the match level is applied.
- R6: A force strobe sets the channel level to the given force level at the next boundary. It takes priority over any match or transition event in the same microcycle.
- R7: If a channel's override is armed (enable bit 1) and the disable line picked by its 2-bit select (value n picks line n, 0 to 3) is high at a boundary, the pin shows the configured override level. This holds whatever the channel level is.
- R8: When the override is unarmed or the selected line is low, the pin shows the channel level. This includes levels set by force or event commands issued while the override was active.
- R9: In a microcycle with no strobe, the channel level holds.
- R10: A buffer enable write sets the buffer enable of every strobed channel to the shared write value at the next boundary. Unstrobed channels keep their enable.
- R11: Two force commands of opposite level in consecutive microcycles produce a pin pulse exactly two clocks wide.
- R12: Strobes to one channel leave the level of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| match_stb | input | NUM_CH | Match event strobe per channel |
| trans_stb | input | NUM_CH | Transition event strobe per channel |
| force_stb | input | NUM_CH | Immediate force strobe per channel |
| force_lvl | input | NUM_CH | Level to force, per channel |
| act_wr | input | NUM_CH | Write strobe for the preset event levels |
| act_match_lvl | input | 1 | Shared data: preset match level |
| act_trans_lvl | input | 1 | Shared data: preset transition level |
| dis_wr | input | NUM_CH | Write strobe for the override configuration |
| dis_en | input | 1 | Shared data: override armed |
| dis_sel | input | 2 | Shared data: which disable line the channel follows |
| dis_lvl | input | 1 | Shared data: level driven while overridden |
| odis_in | input | 4 | Engine-wide disable lines |
| obe_wr | input | NUM_CH | Buffer enable write strobe per channel |
| obe_val | input | 1 | Shared data: buffer enable value |
| pin_out | output | NUM_CH | Registered pin levels |
| obe_out | output | NUM_CH | Registered buffer enables |

## Verification
The bench builds the block with four channels, which matches the four disable lines. With four channels, every one of the sixteen match masks can be combined with every one of the sixteen transition masks under all four preset level pairs, and every force mask with every force level pattern. Each channel is given a different line select, so a sweep over all sixteen disable line patterns hits every select value on every channel, with the override both armed and unarmed and at both override levels. Single-clock strobes and back-to-back force commands then pin down the microcycle alignment and the minimum pulse width.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int unsigned NUM_DIS   = 4;
    localparam int unsigned DIS_SEL_W = $clog2(NUM_DIS);

    // Per-channel override configuration
    typedef struct packed {
        logic                 en;
        logic [DIS_SEL_W-1:0] sel;
        logic                 lvl;
    } dis_cfg_t;

    // Commands collected during the current microcycle
    typedef struct packed {
        logic match;
        logic trans;
        logic frc;
        logic frc_lvl;
        logic obe_v;
        logic obe_lvl;
    } pend_t;

    // Source of the next level, highest priority last
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_EVENT = 2'd1,
        SRC_FORCE = 2'd2,
        SRC_DIS   = 2'd3
    } pin_src_e;

    function automatic pin_src_e pick_src(input logic dis_hit,
                                          input logic frc,
                                          input logic evt);
        pin_src_e s;
        if (dis_hit)  s = SRC_DIS;
        else if (frc) s = SRC_FORCE;
        else if (evt) s = SRC_EVENT;
        else          s = SRC_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/tpc_ucyc_gen.sv
module tpc_ucyc_gen (
    input  logic clk,
    input  logic rst,
    output logic bnd
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign bnd = phase_q;

    // R2
    bnd_alt_chk: assert property (@(posedge clk) disable iff (rst)
        bnd |=> !bnd);

endmodule

// File: rtl/tpc_dis_sel.sv
module tpc_dis_sel #(
    parameter int unsigned NUM_LINES = tpc_pkg::NUM_DIS
) (
    input  logic [NUM_LINES-1:0] lines,
    input  tpc_pkg::dis_cfg_t    cfg,
    output logic                 hit
);
    assign hit = cfg.en & lines[cfg.sel];
endmodule

// File: rtl/tpc_chan.sv
module tpc_chan
    import tpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bnd,
    input  logic                match_stb,
    input  logic                trans_stb,
    input  logic                force_stb,
    input  logic                force_lvl,
    input  logic                act_wr,
    input  logic                act_match_lvl,
    input  logic                act_trans_lvl,
    input  logic                dis_wr,
    input  dis_cfg_t            dis_cfg_in,
    input  logic [NUM_DIS-1:0]  dis_lines,
    input  logic                obe_wr,
    input  logic                obe_val,
    output logic                pin,
    output logic                obe
);
    logic     match_lvl_q, trans_lvl_q;
    dis_cfg_t dis_cfg_q;
    pend_t    pend_q, pend_nxt;
    logic     chan_lvl_q, chan_nxt;
    logic     pin_q, pin_nxt;
    logic     obe_q;
    logic     dis_hit;
    logic     match_e, trans_e, force_e, force_lvl_e, obe_v_e, obe_lvl_e;
    logic     evt_lvl;
    pin_src_e chan_src, pin_src;

    tpc_dis_sel #(.NUM_LINES(NUM_DIS)) u_dis_sel (
        .lines (dis_lines),
        .cfg   (dis_cfg_q),
        .hit   (dis_hit)
    );

    // Merge strobes of this clock with those already pending
    always_comb begin
        match_e     = pend_q.match | match_stb;
        trans_e     = pend_q.trans | trans_stb;
        force_e     = pend_q.frc   | force_stb;
        force_lvl_e = force_stb ? force_lvl : pend_q.frc_lvl;
        obe_v_e     = pend_q.obe_v | obe_wr;
        obe_lvl_e   = obe_wr ? obe_val : pend_q.obe_lvl;

        pend_nxt.match   = match_e;
        pend_nxt.trans   = trans_e;
        pend_nxt.frc     = force_e;
        pend_nxt.frc_lvl = force_lvl_e;
        pend_nxt.obe_v   = obe_v_e;
        pend_nxt.obe_lvl = obe_lvl_e;
    end

    // Resolve next channel level and pin level
    always_comb begin
        evt_lvl  = match_e ? match_lvl_q : trans_lvl_q;
        chan_src = pick_src(1'b0, force_e, match_e | trans_e);
        pin_src  = pick_src(dis_hit, force_e, match_e | trans_e);
        case (chan_src)
            SRC_FORCE: chan_nxt = force_lvl_e;
            SRC_EVENT: chan_nxt = evt_lvl;
            default:   chan_nxt = chan_lvl_q;
        endcase
        pin_nxt = (pin_src == SRC_DIS) ? dis_cfg_q.lvl : chan_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_lvl_q <= 1'b0;
            trans_lvl_q <= 1'b0;
            dis_cfg_q   <= '0;
            pend_q      <= '0;
            chan_lvl_q  <= 1'b0;
            pin_q       <= 1'b0;
            obe_q       <= 1'b0;
        end else begin
            if (act_wr) begin
                match_lvl_q <= act_match_lvl;
                trans_lvl_q <= act_trans_lvl;
            end
            if (dis_wr) dis_cfg_q <= dis_cfg_in;
            if (bnd) begin
                pend_q     <= '0;
                chan_lvl_q <= chan_nxt;
                pin_q      <= pin_nxt;
                if (obe_v_e) obe_q <= obe_lvl_e;
            end else begin
                pend_q <= pend_nxt;
            end
        end
    end

    assign pin = pin_q;
    assign obe = obe_q;

    // R2
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd |=> $stable(pin_q));

    // R10
    obe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd |=> $stable(obe_q));

    // R7
    dis_win_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && dis_hit) |=> (pin_q == $past(dis_cfg_q.lvl)));

    // R6
    force_win_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && force_e) |=> (chan_lvl_q == $past(force_lvl_e)));

    // R5
    match_first_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && !force_e && match_e && trans_e) |=> (chan_lvl_q == $past(match_lvl_q)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && !force_e && !match_e && !trans_e) |=> $stable(chan_lvl_q));

endmodule

// File: rtl/tpc_pin_ctrl.sv
module tpc_pin_ctrl #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             match_stb,
    input  logic [NUM_CH-1:0]             trans_stb,
    input  logic [NUM_CH-1:0]             force_stb,
    input  logic [NUM_CH-1:0]             force_lvl,
    input  logic [NUM_CH-1:0]             act_wr,
    input  logic                          act_match_lvl,
    input  logic                          act_trans_lvl,
    input  logic [NUM_CH-1:0]             dis_wr,
    input  logic                          dis_en,
    input  logic [tpc_pkg::DIS_SEL_W-1:0] dis_sel,
    input  logic                          dis_lvl,
    input  logic [tpc_pkg::NUM_DIS-1:0]   odis_in,
    input  logic [NUM_CH-1:0]             obe_wr,
    input  logic                          obe_val,
    output logic [NUM_CH-1:0]             pin_out,
    output logic [NUM_CH-1:0]             obe_out
);
    import tpc_pkg::*;

    logic     bnd;
    dis_cfg_t dis_cfg_bus;

    assign dis_cfg_bus.en  = dis_en;
    assign dis_cfg_bus.sel = dis_sel;
    assign dis_cfg_bus.lvl = dis_lvl;

    tpc_ucyc_gen u_ucyc (
        .clk (clk),
        .rst (rst),
        .bnd (bnd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tpc_chan u_chan (
            .clk           (clk),
            .rst           (rst),
            .bnd           (bnd),
            .match_stb     (match_stb[c]),
            .trans_stb     (trans_stb[c]),
            .force_stb     (force_stb[c]),
            .force_lvl     (force_lvl[c]),
            .act_wr        (act_wr[c]),
            .act_match_lvl (act_match_lvl),
            .act_trans_lvl (act_trans_lvl),
            .dis_wr        (dis_wr[c]),
            .dis_cfg_in    (dis_cfg_bus),
            .dis_lines     (odis_in),
            .obe_wr        (obe_wr[c]),
            .obe_val       (obe_val),
            .pin           (pin_out[c]),
            .obe           (obe_out[c])
        );
    end

endmodule

// File: tb/tpc_pin_ctrl_bench.sv
module tpc_pin_ctrl_bench;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] match_stb, trans_stb, force_stb, force_lvl;
    logic [NC-1:0] act_wr, dis_wr, obe_wr;
    logic          act_match_lvl, act_trans_lvl, dis_en, dis_lvl, obe_val;
    logic [1:0]    dis_sel;
    logic [3:0]    odis_in;
    logic [NC-1:0] pin_out, obe_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic       m_chan [NC];
    logic       m_ml [NC];
    logic       m_tl [NC];
    logic       m_en [NC];
    logic [1:0] m_sel [NC];
    logic       m_dl [NC];
    logic       m_obe [NC];

    always #4 clk = ~clk;

    tpc_pin_ctrl #(.NUM_CH(NC)) u_tpc_pin_ctrl (
        .clk(clk), .rst(rst),
        .match_stb(match_stb), .trans_stb(trans_stb),
        .force_stb(force_stb), .force_lvl(force_lvl),
        .act_wr(act_wr), .act_match_lvl(act_match_lvl), .act_trans_lvl(act_trans_lvl),
        .dis_wr(dis_wr), .dis_en(dis_en), .dis_sel(dis_sel), .dis_lvl(dis_lvl),
        .odis_in(odis_in), .obe_wr(obe_wr), .obe_val(obe_val),
        .pin_out(pin_out), .obe_out(obe_out)
    );

    task automatic chk(input string req, input int ch, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: got %0b expected %0b", req, ch, act, exp);
        end
    endtask

    task automatic clr();
        match_stb = '0; trans_stb = '0; force_stb = '0; force_lvl = '0;
        act_wr = '0; dis_wr = '0; obe_wr = '0;
    endtask

    // one microcycle: from the negedge before phase 0 to the negedge after the boundary
    task automatic tick();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    function automatic logic exp_pin(input int c);
        return (m_en[c] && odis_in[m_sel[c]]) ? m_dl[c] : m_chan[c];
    endfunction

    task automatic chk_pins(input string req);
        for (int c = 0; c < NC; c++) chk(req, c, pin_out[c], exp_pin(c));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        clr();
        act_match_lvl = 0; act_trans_lvl = 0; dis_en = 0; dis_sel = 0; dis_lvl = 0;
        obe_val = 0; odis_in = '0;
        for (int c = 0; c < NC; c++) begin
            m_chan[c] = 0; m_ml[c] = 0; m_tl[c] = 0; m_en[c] = 0;
            m_sel[c] = 0; m_dl[c] = 0; m_obe[c] = 0;
        end
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        for (int c = 0; c < NC; c++) begin
            chk("R1", c, pin_out[c], 1'b0);
            chk("R1", c, obe_out[c], 1'b0);
        end
        odis_in = 4'hF;
        tick();
        chk_pins("R1");
        odis_in = 4'h0;

        // R3 R4 R5 R9 R12: event sweep under all preset level pairs
        for (int lc = 0; lc < 4; lc++) begin
            act_wr = '1; act_match_lvl = lc[0]; act_trans_lvl = lc[1];
            tick(); clr();
            for (int c = 0; c < NC; c++) begin m_ml[c] = lc[0]; m_tl[c] = lc[1]; end
            for (int m = 0; m < 16; m++) begin
                for (int t = 0; t < 16; t++) begin
                    match_stb = 4'(m); trans_stb = 4'(t);
                    tick(); clr();
                    for (int c = 0; c < NC; c++) begin
                        string tag;
                        if (m[c] && t[c])      begin tag = "R5";  m_chan[c] = m_ml[c]; end
                        else if (m[c])         begin tag = "R3";  m_chan[c] = m_ml[c]; end
                        else if (t[c])         begin tag = "R4";  m_chan[c] = m_tl[c]; end
                        else if ((m | t) != 0) tag = "R12";
                        else                   tag = "R9";
                        chk(tag, c, pin_out[c], exp_pin(c));
                    end
                end
            end
        end

        // R6: force against a simultaneous match (preset match level is 1 here)
        for (int f = 0; f < 16; f++) begin
            for (int fl = 0; fl < 16; fl++) begin
                match_stb = '1; force_stb = 4'(f); force_lvl = 4'(fl);
                tick(); clr();
                for (int c = 0; c < NC; c++) begin
                    m_chan[c] = f[c] ? fl[c] : m_ml[c];
                    chk(f[c] ? "R6" : "R3", c, pin_out[c], exp_pin(c));
                end
            end
        end

        // R7 R8: override sweep; channel c follows line (s+c)%4
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int c = 0; c < NC; c++) begin
                        dis_wr = 4'(1 << c); dis_en = e[0]; dis_lvl = l[0];
                        dis_sel = 2'((s + c) % 4);
                        m_en[c] = e[0]; m_dl[c] = l[0]; m_sel[c] = 2'((s + c) % 4);
                        @(negedge clk);
                    end
                    clr();
                    for (int p = 0; p < 16; p++) begin
                        odis_in = 4'(p);
                        tick();
                        for (int c = 0; c < NC; c++)
                            chk((m_en[c] && odis_in[m_sel[c]]) ? "R7" : "R8",
                                c, pin_out[c], exp_pin(c));
                    end
                end
            end
        end

        // R7 then R8: commands issued under override appear after release
        dis_wr = '1; dis_en = 1; dis_sel = 0; dis_lvl = 1; odis_in = 4'h1;
        force_stb = '1; force_lvl = '0;
        tick(); clr();
        for (int c = 0; c < NC; c++) begin
            m_en[c] = 1; m_sel[c] = 0; m_dl[c] = 1; m_chan[c] = 0;
        end
        chk_pins("R7");
        odis_in = 4'h0;
        tick();
        chk_pins("R8");
        dis_wr = '1; dis_en = 0;
        tick(); clr();
        for (int c = 0; c < NC; c++) m_en[c] = 0;
        chk_pins("R8");

        // R10: buffer enable writes
        for (int p = 0; p < 16; p++) begin
            obe_wr = 4'(p); obe_val = ~p[1];
            tick(); clr();
            for (int c = 0; c < NC; c++) begin
                if (p[c]) m_obe[c] = ~p[1];
                chk("R10", c, obe_out[c], m_obe[c]);
            end
        end

        // R2: a single-clock strobe on the first edge lands on the next edge
        begin
            logic old_v;
            old_v = m_chan[0];
            force_stb = 4'b0001; force_lvl = {NC{~old_v}};
            @(posedge clk); @(negedge clk);
            clr();
            chk("R2", 0, pin_out[0], old_v);
            @(posedge clk); @(negedge clk);
            m_chan[0] = ~old_v;
            chk("R2", 0, pin_out[0], ~old_v);
        end

        // R11: one-microcycle pulse is two clocks wide
        force_stb = 4'b0001; force_lvl = '0;
        tick();
        force_lvl = 4'b0001;
        tick();
        force_lvl = '0;
        begin
            int hi = 0;
            for (int k = 0; k < 6; k++) begin
                if (pin_out[0]) hi++;
                @(negedge clk);
            end
            n_chk++;
            if (hi != 2) begin
                n_bad++;
                $display("FAIL R11 ch0: got %0d clocks expected 2", hi);
            end
        end
        clr();
        m_chan[0] = 0;
        tick();
        chk_pins("R11");

        done = 1;
        summary();
    end

endmodule